// File: doc/BRIEF.md
# Segmented Look-Ahead Binary Up Counter

This block is an 8-bit synchronous binary up counter. No carry chain runs through all of its bits. The count is split into three toggle-cell segments of 3, 3 and 2 bits, from least to most significant. The lowest segment advances on every enabled cycle. Each higher segment advances only when a one-bit look-ahead flag says that every lower bit is at 1.

Each look-ahead flag is a flip-flop, loaded one enabled cycle early. Within one clock period, the longest path is therefore the carry across a single segment plus one AND gate. The full count can be read in every cycle, with no settling delay.

The counter has a synchronous reset and a count enable. When the enable is low, every register holds, including the look-ahead flags. The count wraps from 255 to 0.

Top module: `lac_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 0 after that edge, whatever the value of `cnt_en`.
- R2: When `cnt_en` is high and `rst` is low at an edge, `count` becomes the previous count plus one after that edge.
- R3: When `cnt_en` is low and `rst` is low at an edge, `count` keeps its value. Counting resumes from that value as soon as the enable returns.
- R4: On an enabled edge, a count of 255 becomes 0.
- R5: Bits [5:3] of `count` increment exactly on the enabled edge where bits [2:0] go from 7 to 0, and at no other edge.
- R6: Bits [7:6] of `count` increment exactly on the enabled edge where bits [5:0] go from 63 to 0.
- R7: The look-ahead flag for a higher segment is 1 exactly when all lower count bits are 1, in every cycle after reset.
- R8: Under any mix of enable and reset patterns, `count` equals a plain behavioural counter on every cycle.
- R9: A reset that arrives while a look-ahead flag is set also clears that flag. After such a reset, the next enabled edge gives a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; when low, all state holds |
| count | output | 8 | Current count value |

## Verification
A look-ahead flag that is wrong by one cycle shows up at the ports as a higher segment that increments early or late. The error appears at the next 7-to-0 rollover of the bits below that segment, which is at most 8 or 64 enabled cycles away. Holding the enable low, or resetting, while a flag is set would expose a flag that fails to hold or fails to clear, on the very next enabled edge. The bench therefore compares the count with a reference value every cycle. It places pauses and resets exactly on the 7, 63 and 255 boundaries.

// File: rtl/lac_pkg.sv
package lac_pkg;
    // look-ahead flags for the two upper segments
    typedef struct packed {
        logic mid_go;
        logic top_go;
    } look_t;
endpackage

// File: rtl/lac_segment.sv
module lac_segment #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] val;
    } seg_t;

    seg_t         st_d, st_q;
    logic [W-1:0] tog;

    // toggle condition per cell: segment advance AND all lower cells set
    assign tog[0] = adv;
    generate
        for (genvar i = 1; i < W; i++) begin : g_tog
            assign tog[i] = tog[i-1] & st_q.val[i-1];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.val = st_q.val ^ tog;
        if (rst) st_d.val = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign val = st_q.val;

    // R5
    seg_rollover_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && (&val)) |=> (val == '0));

    // R3
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(val));
endmodule

// File: rtl/lac_lookahead.sv
module lac_lookahead
    import lac_pkg::*;
#(
    parameter int W0 = 3,
    parameter int W1 = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic [W0-1:0] low_v,
    input  logic [W1-1:0] mid_v,
    output look_t         look
);
    localparam logic [W0-1:0] LOW_ONES = {W0{1'b1}};
    localparam logic [W0-1:0] LOW_PRE  = LOW_ONES - 1'b1;

    look_t look_d, look_q;

    always_comb begin
        look_d = look_q;
        if (cnt_en) begin
            look_d.mid_go = (low_v == LOW_PRE);
            look_d.top_go = (low_v == LOW_PRE) && (&mid_v);
        end
        if (rst) look_d = '0;
    end

    always_ff @(posedge clk) begin
        look_q <= look_d;
    end

    assign look = look_q;

    // R7
    mid_flag_chk: assert property (@(posedge clk) disable iff (rst)
        look_q.mid_go == (&low_v));

    // R7
    top_flag_chk: assert property (@(posedge clk) disable iff (rst)
        look_q.top_go == ((&low_v) && (&mid_v)));
endmodule

// File: rtl/lac_counter.sv
module lac_counter
    import lac_pkg::*;
#(
    parameter int W0 = 3,
    parameter int W1 = 3,
    parameter int W2 = 2,
    localparam int TW = W0 + W1 + W2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};

    logic [W0-1:0] low_v;
    logic [W1-1:0] mid_v;
    logic [W2-1:0] top_v;
    look_t         look;
    logic          adv_lo, adv_mid, adv_top;

    assign adv_lo  = cnt_en;
    assign adv_mid = cnt_en & look.mid_go;
    assign adv_top = cnt_en & look.top_go;

    lac_segment #(.W(W0)) u_lo  (.clk(clk), .rst(rst), .adv(adv_lo),  .val(low_v));
    lac_segment #(.W(W1)) u_mid (.clk(clk), .rst(rst), .adv(adv_mid), .val(mid_v));
    lac_segment #(.W(W2)) u_top (.clk(clk), .rst(rst), .adv(adv_top), .val(top_v));

    lac_lookahead #(.W0(W0), .W1(W1)) u_look (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .low_v(low_v), .mid_v(mid_v), .look(look)
    );

    assign count = {top_v, mid_v, low_v};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count != MAXV) |=> (count == $past(count) + 1'b1));

    // R3
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == MAXV) |=> (count == '0));
endmodule

// File: tb/sim_lac_counter.sv
`timescale 1ns/1ps
module sim_lac_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [7:0] count;
    logic [7:0] exp_cnt = 8'd0;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    lac_counter u0 (.clk(clk), .rst(rst), .cnt_en(cnt_en), .count(count));

    function automatic logic [7:0] model_next(input logic [7:0] cur, input logic r, input logic e);
        if (r) return 8'd0;
        if (e) return cur + 8'd1;
        return cur;
    endfunction

    function automatic string pick_tag(input logic [7:0] prev, input logic r, input logic e);
        if (r) return "R1";
        if (!e) return "R3";
        if (prev == 8'd255) return "R4";
        if (prev[5:0] == 6'd63) return "R6";
        if (prev[2:0] == 3'd7) return "R5";
        return "R2";
    endfunction

    // called at a falling edge; drives, waits one rising edge, checks at the next falling edge
    task automatic cyc(input logic r, input logic e, input string ph);
        logic [7:0] prev;
        string      tg;
        prev   = exp_cnt;
        tg     = pick_tag(prev, r, e);
        rst    = r;
        cnt_en = e;
        @(posedge clk);
        exp_cnt = model_next(prev, r, e);
        @(negedge clk);
        total++;
        if (count !== exp_cnt) begin
            bad++;
            $display("FAIL %s %s: count=%0d expected=%0d (prev=%0d rst=%0b en=%0b)",
                     tg, ph, count, exp_cnt, prev, r, e);
        end
    endtask

    task automatic run_to(input logic [7:0] target);
        while (exp_cnt != target) cyc(1'b0, 1'b1, "advance");
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: count=%0d expected=finished", count);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state, enable high or low
        cyc(1'b1, 1'b0, "reset");
        cyc(1'b1, 1'b1, "reset with enable");
        // R2 R5 R6 R4: two full passes with the enable held high
        for (int i = 0; i < 520; i++) cyc(1'b0, 1'b1, "free run");
        // R3: pause while bits [2:0] are all ones, so the middle flag is set
        run_to(8'd7);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "pause at 7");
        cyc(1'b0, 1'b1, "resume 7->8");
        // R3 R6: pause at 63, where both flags are set
        run_to(8'd63);
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, "pause at 63");
        cyc(1'b0, 1'b1, "resume 63->64");
        // R4: pause at 255, then wrap
        run_to(8'd255);
        cyc(1'b0, 1'b0, "pause at 255");
        cyc(1'b0, 1'b1, "wrap");
        // R9: reset while flags are set; the next step must give 1
        run_to(8'd7);
        cyc(1'b1, 1'b1, "R9 reset at 7");
        cyc(1'b0, 1'b1, "R9 step after reset");
        run_to(8'd63);
        cyc(1'b1, 1'b0, "R9 reset at 63");
        cyc(1'b0, 1'b1, "R9 step after reset");
        // R8: random enable and occasional reset
        for (int i = 0; i < 4000; i++) begin
            logic e;
            logic r;
            e = (($urandom % 10) < 7);
            r = (($urandom % 150) == 0);
            cyc(r, e, "R8 random");
        end
        // R8: enable toggling every cycle across a full wrap
        for (int i = 0; i < 600; i++) cyc(1'b0, i[0], "R8 alternate");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule